// File: doc/BRIEF.md
# PLL Bypass and Relock Sequencer

This block holds the control settings of a clock-multiplier unit and walks it through a safe retune whenever its multiplier changes. Software uses a small register port to set the control bits and stage a new multiplier value. It then writes a start command. A hardware state machine takes over from there. It moves the output onto the reference clock by clearing the enable and enable-source bits. It waits a number of reference ticks, then holds the multiplier in reset and clears the disable bit. After a reset interval it releases reset and hands the staged multiplier to the unit. It waits out the lock interval and the lock indication, and only then selects the multiplied clock again.

Every wait is counted in reference-clock ticks. A single-cycle `ref_tick` pulse marks each reference period. Separate parameters set the bypass settle time, the reset time and the ratio of lock time to reset time. The multiplier field can be read in two ways, chosen by a parameter. The normal reading gives reference × (field + 1). The alternate reading gives reference × (field × 2). The resulting factor is driven on a port.

Top module: `pll_relock_seq`

Register map. The address is 2 bits and the data is `DW` bits:

| Address | Register | Access |
|---|---|---|
| 0 | control | read and write |
| 1 | staged multiplier field | read and write |
| 2 | status | read only |
| 3 | command | write only, reads as 0 |

## Requirements
- R1: After reset:
  - the control register reads 0x010, meaning bypass, in reset, disabled and all other bits clear;
  - the multiplier register reads `MULT_RST`;
  - status reads 0;
  - `pll_mult` equals `MULT_RST`.
- R2: The control register has six writable bits, each driving one output:
  - bit 0 drives `pll_en`;
  - bit 1 drives `pll_pwrdn`;
  - bit 3 drives `pll_rst_n`, where 0 holds the multiplier in reset;
  - bit 4 drives `pll_dis`;
  - bit 5 drives `pll_ensrc`;
  - bit 8 drives `pll_clkmode`.
  
  Software writes take effect while idle and show on the next cycle. All other bits read 0.
- R3: A write to address 1 is accepted only when the whole data word lies within `MULT_MIN`..`MULT_MAX`. Any other write leaves the staged value unchanged.
- R4: Writing address 3 with bit 0 set while idle does three things on the same clock edge: it clears `pll_en` and `pll_ensrc`, and it raises `busy`.
- R5: Exactly `BYPASS_TICKS` reference ticks after the bypass step, `pll_rst_n` and `pll_dis` are both cleared on one edge. `BYPASS_TICKS` must be at least 4.
- R6: Exactly `RESET_TICKS` ticks later, `pll_rst_n` is set and the staged field appears on `pll_mult` on that same edge. `pll_mult` changes at no other time.
- R7: `pll_en` is set only when two conditions hold: `LOCK_RATIO`×`RESET_TICKS` ticks have passed since the release, and `pll_lock` is high. If lock arrives late, `pll_en` rises two clock edges after `pll_lock` is first sampled high.
- R8: `busy` stays high from the bypass step until the edge that sets `pll_en`, and falls on that edge. Status bit 0 reads `busy` and status bit 1 reads `pll_lock`.
- R9: While `busy` is high, control writes and command writes are ignored. Multiplier writes are still staged and are applied at the release step.
- R10: `mult_factor` equals `pll_mult`+1 when `ALT_MULT`=0, and `pll_mult`×2 when `ALT_MULT`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle pulse per reference-clock period |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr`, combinational |
| pll_lock | input | 1 | Lock indication from the multiplier unit |
| pll_en | output | 1 | 1 selects the multiplied clock, 0 selects bypass |
| pll_pwrdn | output | 1 | Power-down request |
| pll_rst_n | output | 1 | Multiplier reset, active low |
| pll_dis | output | 1 | Multiplier disable |
| pll_ensrc | output | 1 | Enable-source select |
| pll_clkmode | output | 1 | Input clock mode |
| pll_mult | output | MW | Applied multiplier field |
| mult_factor | output | MW+1 | Effective multiplication factor |
| busy | output | 1 | Retune sequence in progress |

## Verification
Control and multiplier writes are captured on the next clock edge. The bench reads them back one cycle later, on the falling edge. The bypass outputs and `busy` are checked on the falling edge right after the command is captured. The bench counts the reference ticks it delivers on falling edges and snapshots that count when each sequence output changes. This lets it require exactly `BYPASS_TICKS` ticks between bypass and reset, and exactly `RESET_TICKS` ticks between reset and release. The lock step has two extra clock edges, so the enable must come between `LOCK_RATIO`×`RESET_TICKS` and one more tick after the release. When lock is late, the enable must come exactly two clocks after the model raises lock.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BYPASS_WAIT,
        ST_RESET_HOLD,
        ST_LOCK_WAIT,
        ST_ENABLE
    } seq_state_e;

    // control bit positions
    localparam int CB_EN    = 0;
    localparam int CB_PWRDN = 1;
    localparam int CB_RSTN  = 3;
    localparam int CB_DIS   = 4;
    localparam int CB_ENSRC = 5;
    localparam int CB_MODE  = 8;
    localparam int CTRL_W   = 9;

    localparam logic [CTRL_W-1:0] CTRL_MASK  = 9'h13B;
    localparam logic [CTRL_W-1:0] CTRL_RESET = 9'h010;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_MULT = 2'd1;
    localparam logic [1:0] RA_STAT = 2'd2;
    localparam logic [1:0] RA_CMD  = 2'd3;

endpackage

// File: rtl/pll_tick_timer.sv
module pll_tick_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          tick,
    output logic          done
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (tick && (cnt_q != '0))
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done); // R5

    AST_TMR_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(cnt_q)); // R5

endmodule

// File: rtl/pll_mult_stage.sv
module pll_mult_stage #(
    parameter int DW       = 16,
    parameter int MW       = 5,
    parameter int MULT_MIN = 4,
    parameter int MULT_MAX = 24,
    parameter int MULT_RST = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          apply,
    output logic [MW-1:0] staged,
    output logic [MW-1:0] applied
);
    typedef struct packed {
        logic [MW-1:0] staged;
        logic [MW-1:0] applied;
    } mult_t;

    mult_t cur_q, nxt_d;
    logic  in_range;

    assign in_range = (wdata >= DW'(MULT_MIN)) && (wdata <= DW'(MULT_MAX));

    always_comb begin
        nxt_d = cur_q;
        if (wr && in_range)
            nxt_d.staged = wdata[MW-1:0];
        if (apply)
            nxt_d.applied = cur_q.staged;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.staged  <= MW'(MULT_RST);
            cur_q.applied <= MW'(MULT_RST);
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign staged  = cur_q.staged;
    assign applied = cur_q.applied;

    AST_MULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !in_range) |=> $stable(staged)); // R3

    AST_MULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(applied)); // R6

endmodule

// File: rtl/pll_rate_scale.sv
module pll_rate_scale #(
    parameter int MW       = 5,
    parameter bit ALT_MULT = 1'b0
) (
    input  logic [MW-1:0] field,
    output logic [MW:0]   factor
);
    generate
        if (ALT_MULT) begin : g_double
            assign factor = {field, 1'b0};
        end else begin : g_plus_one
            assign factor = {1'b0, field} + (MW+1)'(1);
        end
    endgenerate
endmodule

// File: rtl/pll_relock_seq.sv
module pll_relock_seq
    import pll_seq_pkg::*;
#(
    parameter int DW           = 16,
    parameter int MW           = 5,
    parameter int MULT_MIN     = 4,
    parameter int MULT_MAX     = 24,
    parameter int MULT_RST     = 4,
    parameter bit ALT_MULT     = 1'b0,
    parameter int BYPASS_TICKS = 4,
    parameter int RESET_TICKS  = 25,
    parameter int LOCK_RATIO   = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_tick,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          pll_lock,
    output logic          pll_en,
    output logic          pll_pwrdn,
    output logic          pll_rst_n,
    output logic          pll_dis,
    output logic          pll_ensrc,
    output logic          pll_clkmode,
    output logic [MW-1:0] pll_mult,
    output logic [MW:0]   mult_factor,
    output logic          busy
);
    localparam int LOCK_TICKS = LOCK_RATIO * RESET_TICKS;
    localparam int MAX_AB     = (BYPASS_TICKS > RESET_TICKS) ? BYPASS_TICKS : RESET_TICKS;
    localparam int MAX_TICKS  = (MAX_AB > LOCK_TICKS) ? MAX_AB : LOCK_TICKS;
    localparam int CW         = $clog2(MAX_TICKS + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [CTRL_W-1:0] ctrl;
    } seq_t;

    seq_t          cur_q, nxt_d;
    logic          tmr_load, tmr_done, mult_apply, mult_wr;
    logic [CW-1:0] tmr_val;
    logic [MW-1:0] staged;

    assign mult_wr = reg_wr && (reg_addr == RA_MULT);

    always_comb begin
        nxt_d      = cur_q;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        mult_apply = 1'b0;
        case (cur_q.st)
            ST_IDLE: begin
                if (reg_wr && reg_addr == RA_CTRL)
                    nxt_d.ctrl = reg_wdata[CTRL_W-1:0] & CTRL_MASK;
                if (reg_wr && reg_addr == RA_CMD && reg_wdata[0]) begin
                    nxt_d.ctrl[CB_EN]    = 1'b0;
                    nxt_d.ctrl[CB_ENSRC] = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(BYPASS_TICKS);
                    nxt_d.st = ST_BYPASS_WAIT;
                end
            end
            ST_BYPASS_WAIT: begin
                if (tmr_done) begin
                    nxt_d.ctrl[CB_RSTN] = 1'b0;
                    nxt_d.ctrl[CB_DIS]  = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(RESET_TICKS);
                    nxt_d.st = ST_RESET_HOLD;
                end
            end
            ST_RESET_HOLD: begin
                if (tmr_done) begin
                    nxt_d.ctrl[CB_RSTN] = 1'b1;
                    mult_apply = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(LOCK_TICKS);
                    nxt_d.st = ST_LOCK_WAIT;
                end
            end
            ST_LOCK_WAIT: begin
                if (tmr_done && pll_lock)
                    nxt_d.st = ST_ENABLE;
            end
            ST_ENABLE: begin
                nxt_d.ctrl[CB_EN] = 1'b1;
                nxt_d.st = ST_IDLE;
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st   <= ST_IDLE;
            cur_q.ctrl <= CTRL_RESET;
        end else begin
            cur_q <= nxt_d;
        end
    end

    pll_tick_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .tick     (ref_tick),
        .done     (tmr_done)
    );

    pll_mult_stage #(
        .DW(DW), .MW(MW), .MULT_MIN(MULT_MIN), .MULT_MAX(MULT_MAX), .MULT_RST(MULT_RST)
    ) u_mult (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (mult_wr),
        .wdata   (reg_wdata),
        .apply   (mult_apply),
        .staged  (staged),
        .applied (pll_mult)
    );

    pll_rate_scale #(.MW(MW), .ALT_MULT(ALT_MULT)) u_scale (
        .field  (pll_mult),
        .factor (mult_factor)
    );

    assign busy        = (cur_q.st != ST_IDLE);
    assign pll_en      = cur_q.ctrl[CB_EN];
    assign pll_pwrdn   = cur_q.ctrl[CB_PWRDN];
    assign pll_rst_n   = cur_q.ctrl[CB_RSTN];
    assign pll_dis     = cur_q.ctrl[CB_DIS];
    assign pll_ensrc   = cur_q.ctrl[CB_ENSRC];
    assign pll_clkmode = cur_q.ctrl[CB_MODE];

    always_comb begin
        case (reg_addr)
            RA_CTRL: reg_rdata = {{(DW-CTRL_W){1'b0}}, cur_q.ctrl};
            RA_MULT: reg_rdata = {{(DW-MW){1'b0}}, staged};
            RA_STAT: reg_rdata = {{(DW-2){1'b0}}, pll_lock, busy};
            default: reg_rdata = '0;
        endcase
    end

    AST_BYPASS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!pll_en && !pll_ensrc)); // R4

    AST_RESET_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $fell(pll_rst_n)) |-> !pll_dis); // R5

    AST_EN_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pll_en) && $past(busy)) |-> $past(pll_lock)); // R7

    AST_EN_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !pll_en); // R8

    AST_BUSY_FALL_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> pll_en); // R8

endmodule

// File: tb/tb_pll_relock_seq.sv
module tb_pll_relock_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int MW = 5;
    localparam int MRST = 4;
    localparam int BYP = 4;
    localparam int RSTT = 3;
    localparam int RATIO = 20;
    localparam int LOCKT = RATIO * RSTT;
    localparam int TICK_DIV = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_tick = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata, alt_rdata;
    logic          pll_lock = 1'b0;
    logic          pll_en, pll_pwrdn, pll_rst_n, pll_dis, pll_ensrc, pll_clkmode, busy;
    logic [MW-1:0] pll_mult, alt_mult;
    logic [MW:0]   mult_factor, alt_factor;
    logic          a_en, a_pwrdn, a_rstn, a_dis, a_ensrc, a_mode, a_busy;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_relock_seq #(.DW(DW), .MW(MW), .MULT_MIN(4), .MULT_MAX(24), .MULT_RST(MRST),
        .ALT_MULT(1'b0), .BYPASS_TICKS(BYP), .RESET_TICKS(RSTT), .LOCK_RATIO(RATIO)) dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pll_lock(pll_lock), .pll_en(pll_en),
        .pll_pwrdn(pll_pwrdn), .pll_rst_n(pll_rst_n), .pll_dis(pll_dis), .pll_ensrc(pll_ensrc),
        .pll_clkmode(pll_clkmode), .pll_mult(pll_mult), .mult_factor(mult_factor), .busy(busy));

    pll_relock_seq #(.DW(DW), .MW(MW), .MULT_MIN(4), .MULT_MAX(24), .MULT_RST(MRST),
        .ALT_MULT(1'b1), .BYPASS_TICKS(BYP), .RESET_TICKS(RSTT), .LOCK_RATIO(RATIO)) dut_alt (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(alt_rdata), .pll_lock(pll_lock), .pll_en(a_en),
        .pll_pwrdn(a_pwrdn), .pll_rst_n(a_rstn), .pll_dis(a_dis), .pll_ensrc(a_ensrc),
        .pll_clkmode(a_mode), .pll_mult(alt_mult), .mult_factor(alt_factor), .busy(a_busy));

    int n_run = 0, n_fail = 0;
    int cyc = 0, tick_total = 0, tdiv = 0;
    int model_lock = 10, lock_cnt = 0;
    int snap_byp, snap_fall, snap_rel, snap_en, cyc_en, cyc_lock;
    logic dis_at_fall;
    logic [MW-1:0] mult_before, mult_at;
    logic p_busy = 1'b0, p_rstn = 1'b0, p_en = 1'b0;
    logic [MW-1:0] p_mult = '0;

    // monitor, reference tick source and abstract lock model
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (busy && !p_busy) snap_byp = tick_total;
            if (busy && !pll_rst_n && p_rstn) begin
                snap_fall = tick_total; dis_at_fall = pll_dis;
            end
            if (busy && pll_rst_n && !p_rstn) begin
                snap_rel = tick_total; mult_before = p_mult; mult_at = pll_mult;
            end
            if (pll_en && !p_en && p_busy) begin
                snap_en = tick_total; cyc_en = cyc;
            end
        end
        p_busy = busy; p_rstn = pll_rst_n; p_en = pll_en; p_mult = pll_mult;
        tdiv = (tdiv + 1) % TICK_DIV;
        ref_tick = (tdiv == 0);
        if (ref_tick) tick_total++;
        if (!pll_rst_n || pll_pwrdn) begin
            lock_cnt = 0; pll_lock = 1'b0;
        end else begin
            if (ref_tick && lock_cnt < model_lock) lock_cnt++;
            if (!pll_lock && lock_cnt >= model_lock) begin
                pll_lock = 1'b1; cyc_lock = cyc;
            end
        end
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_range(input string req, input int act, input int lo, input int hi);
        n_run++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output int v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            #1;
            if (!busy) return;
        end
        chk("R8 busy never fell", 1, 0);
    endtask

    task automatic t_reset();
        int v;
        reg_read(2'd0, v); chk("R1 ctrl reset", v, 'h010);
        reg_read(2'd1, v); chk("R1 mult reset", v, MRST);
        reg_read(2'd2, v); chk("R1 status reset", v, 0);
        chk("R1 outputs", {pll_en, pll_rst_n, pll_dis, busy}, 4'b0010);
        chk("R1 pll_mult", int'(pll_mult), MRST);
        chk("R10 factor plus one", int'(mult_factor), MRST + 1);
        chk("R10 factor double", int'(alt_factor), MRST * 2);
    endtask

    task automatic t_ctrl_bits();
        int v;
        reg_write(2'd0, 16'hFFFF);
        reg_read(2'd0, v); chk("R2 writable mask", v, 'h13B);
        chk("R2 outputs all set", {pll_en, pll_pwrdn, pll_rst_n, pll_dis, pll_ensrc, pll_clkmode}, 6'b111111);
        reg_write(2'd0, 16'h0102);
        reg_read(2'd0, v); chk("R2 pattern readback", v, 'h102);
        chk("R2 outputs pattern", {pll_en, pll_pwrdn, pll_rst_n, pll_dis, pll_ensrc, pll_clkmode}, 6'b010001);
        reg_write(2'd0, 16'h0000);
    endtask

    task automatic t_mult_range();
        int v;
        reg_write(2'd1, 16'd3);  reg_read(2'd1, v); chk("R3 below min ignored", v, MRST);
        reg_write(2'd1, 16'd25); reg_read(2'd1, v); chk("R3 above max ignored", v, MRST);
        reg_write(2'd1, 16'h0027); reg_read(2'd1, v); chk("R3 wide value ignored", v, MRST);
        reg_write(2'd1, 16'd24); reg_read(2'd1, v); chk("R3 max accepted", v, 24);
        reg_write(2'd1, 16'd7);  reg_read(2'd1, v); chk("R3 mid accepted", v, 7);
        chk("R6 no apply while idle", int'(pll_mult), MRST);
    endtask

    task automatic t_sequence();
        int v;
        model_lock = 10;
        reg_write(2'd0, 16'h0029);
        reg_write(2'd3, 16'h0001);
        #1;
        chk("R4 bypass entry", {busy, pll_en, pll_ensrc}, 3'b100);
        reg_read(2'd2, v); chk("R8 status busy bit", v & 1, 1);
        wait_idle();
        chk("R5 bypass ticks", snap_fall - snap_byp, BYP);
        chk("R5 dis cleared with reset", int'(dis_at_fall), 0);
        chk("R6 reset ticks", snap_rel - snap_fall, RSTT);
        chk("R6 mult before release", int'(mult_before), MRST);
        chk("R6 mult at release", int'(mult_at), 7);
        chk_range("R7 lock wait ticks", snap_en - snap_rel, LOCKT, LOCKT + 1);
        chk("R8 idle enabled", {busy, pll_en}, 2'b01);
        reg_read(2'd2, v); chk("R8 status idle locked", v, 2);
        reg_read(2'd0, v); chk("R4 ctrl after sequence", v, 'h009);
        chk("R10 factor plus one", int'(mult_factor), 8);
        chk("R10 factor double", int'(alt_factor), 14);
    endtask

    task automatic t_busy_writes();
        int v;
        model_lock = 10;
        reg_write(2'd3, 16'h0001);
        reg_write(2'd1, 16'd9);
        reg_write(2'd0, 16'h0102);
        reg_write(2'd3, 16'h0001);
        #1;
        chk("R9 ctrl write ignored", {pll_pwrdn, pll_clkmode}, 2'b00);
        chk("R9 staged not applied early", int'(pll_mult), 7);
        reg_read(2'd1, v); chk("R9 staged during busy", v, 9);
        wait_idle();
        chk("R9 applied at release", int'(mult_at), 9);
        repeat (20) @(negedge clk);
        #1;
        chk("R9 command ignored while busy", int'(busy), 0);
        chk("R10 factor plus one", int'(mult_factor), 10);
    endtask

    task automatic t_late_lock();
        model_lock = LOCKT + 20;
        reg_write(2'd3, 16'h0001);
        wait_idle();
        chk("R7 en two clocks after lock", cyc_en - cyc_lock, 2);
        chk_range("R7 late lock ticks", snap_en - snap_rel, LOCKT + 20, LOCKT + 22);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl_bits();
        t_mult_range();
        t_sequence();
        t_busy_writes();
        t_late_lock();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule